// File: doc/BRIEF.md
# Packed Alternating Double-Precision Add/Subtract Unit

This block runs on 64-bit IEEE-754 double-precision lanes. It takes two 256-bit vectors and applies a different operation to each lane depending on the lane's position. Lanes in even positions return the first operand minus the second. Lanes in odd positions return their sum. All results are rounded to nearest, with ties going to even.

A two-bit width select decides what happens to the upper half of the result.

- In the destructive 128-bit form, the first operand stands in for the destination. The upper 128 bits come back unchanged from the supplied prior destination value.
- In the non-destructive 128-bit form, only the two low lanes are computed, and the upper half is cleared.
- In the 256-bit form, all four lanes are computed.

The block has one register stage. A request that is valid on one clock edge produces a result, a five-bit exception flag vector and a valid strobe after that edge. The flags are the OR of the flags from every active lane. Decode, memory access, traps and masking belong to the surrounding pipeline.

Top module: `fp64_altsub_unit`

## Requirements
- R1: Lane 0 (bits 63:0) and lane 2 (bits 191:128) return op_a minus op_b. Subtraction inverts the sign of op_b and then adds.
- R2: Lane 1 (bits 127:64) and lane 3 (bits 255:192) return op_a plus op_b.
- R3: Mode 0 (destructive 128-bit) computes lanes 0 and 1. Result bits 255:128 equal old_dst[255:128] as sampled with the request.
- R4: Mode 1 (non-destructive 128-bit) computes lanes 0 and 1 and returns zero in bits 255:128. Lanes 2 and 3 contribute no flags.
- R5: Mode 2 computes all four lanes, and mode 3 behaves exactly as mode 2.
- R6: Every finite result is the correctly rounded value under round-to-nearest-even.
- R7: Either of these returns 0xFFF8000000000000 and sets the invalid flag: an operand that is a NaN (quiet or signalling), or an effective sum of two infinities of opposite sign.
- R8: A zero result from operands of opposite effective sign is +0. The sum of two zeros of the same sign keeps that sign.
- R9: A finite sum too large to represent returns infinity of the result's sign and sets both the overflow and precision flags.
- R10: The denormal flag is set when any operand of an active lane is subnormal. Subnormal inputs are used at full precision, not flushed.
- R11: The precision flag is set when rounding changes the value. The underflow flag is set when the pre-rounding result is below the smallest normal magnitude and inexact.
- R12: Flags are bit 0 invalid, bit 1 denormal, bit 2 overflow, bit 3 underflow, bit 4 precision. Each bit is ORed over the active lanes.
  - out_valid, result and flags update one cycle after in_valid and hold otherwise.
  - Reset clears all three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| mode | input | 2 | 0 destructive 128-bit, 1 non-destructive 128-bit, 2 or 3 256-bit |
| op_a | input | 256 | First source, four doubles |
| op_b | input | 256 | Second source, four doubles |
| old_dst | input | 256 | Prior destination value, used for the upper half in mode 0 |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| result | output | 256 | Packed results |
| flags | output | 5 | Exception flags ORed across active lanes |

## Verification
The datapath holds no state beyond its output register, so a fault shows in the very next result word, one cycle after the request that provokes it. Any of the following errors would show there:
- a misplaced sticky bit or off-by-one normalisation shift gives a result one ulp off;
- a wrong lane-parity decode swaps the signs of whole lanes;
- a bad mode decode leaks computed data or stale destination bits into the upper half.

Flag errors show in the same cycle as missing or extra flag bits. Examples are OR-ing flags from inactive lanes, or dropping precision on overflow. The sweep crosses every pair from a set of special and boundary values in every lane, then checks randomly drawn operands against the host's own double arithmetic.

// File: rtl/fp64_altsub_unit.sv
module fp64_altsub_unit #(
  parameter int LANES = 4,
  parameter int FW = 64,
  parameter int XW = 11,
  parameter int MW = 52
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [1:0]            mode,
  input  logic [LANES*FW-1:0]   op_a,
  input  logic [LANES*FW-1:0]   op_b,
  input  logic [LANES*FW-1:0]   old_dst,
  output logic                  out_valid,
  output logic [LANES*FW-1:0]   result,
  output logic [4:0]            flags
);
  localparam int VW   = LANES * FW;
  localparam int HALF = VW / 2;
  localparam int SW   = MW + 4;
  localparam logic [XW-1:0] XMAX = {XW{1'b1}};
  localparam logic [FW-1:0] QNAN = {1'b1, XMAX, 1'b1, {(MW-1){1'b0}}};

  function automatic logic [FW+4:0] lane_op(input logic [FW-1:0] a, input logic [FW-1:0] b_in,
                                            input logic sub);
    logic [FW-1:0] b, res;
    logic sa, sb, sl, ss, eff_sub, swap, a_nan, b_nan, a_inf, b_inf;
    logic inv, den, ovf, unf, prec, tiny, inexact, inc;
    logic [XW-1:0] ea, eb;
    logic [MW-1:0] fa, fb;
    logic [SW-1:0] ma, mb, ml, ms, msh, m;
    logic [SW:0] sum;
    logic [12:0] el, es, d, e, lz, sh;
    logic [5:0] dc;
    logic [MW+1:0] rm;
    b = {b_in[FW-1] ^ sub, b_in[FW-2:0]};
    sa = a[FW-1]; sb = b[FW-1];
    ea = a[FW-2:MW]; eb = b[FW-2:MW];
    fa = a[MW-1:0]; fb = b[MW-1:0];
    a_nan = (ea == XMAX) && (fa != '0);
    b_nan = (eb == XMAX) && (fb != '0);
    a_inf = (ea == XMAX) && (fa == '0);
    b_inf = (eb == XMAX) && (fb == '0);
    den = ((ea == '0) && (fa != '0)) || ((eb == '0) && (fb != '0));
    inv = 1'b0; ovf = 1'b0; unf = 1'b0; prec = 1'b0;
    res = '0;
    if (a_nan || b_nan || (a_inf && b_inf && (sa != sb))) begin
      res = QNAN;
      inv = 1'b1;
    end else if (a_inf) begin
      res = a;
    end else if (b_inf) begin
      res = b;
    end else begin
      ma = {ea != '0, fa, 3'b000};
      mb = {eb != '0, fb, 3'b000};
      swap = {ea, fa} < {eb, fb};
      sl = swap ? sb : sa;
      ss = swap ? sa : sb;
      ml = swap ? mb : ma;
      ms = swap ? ma : mb;
      el = {2'b00, swap ? ((eb == '0) ? 11'd1 : eb) : ((ea == '0) ? 11'd1 : ea)};
      es = {2'b00, swap ? ((ea == '0) ? 11'd1 : ea) : ((eb == '0) ? 11'd1 : eb)};
      d = el - es;
      dc = (d > 13'd57) ? 6'd57 : d[5:0];
      msh = ms >> dc;
      msh[0] = msh[0] | (|(ms & ~({SW{1'b1}} << dc)));
      eff_sub = sl ^ ss;
      sum = eff_sub ? ({1'b0, ml} - {1'b0, msh}) : ({1'b0, ml} + {1'b0, msh});
      if (sum == '0) begin
        res = {eff_sub ? 1'b0 : sl, {(FW-1){1'b0}}};
      end else begin
        e = el;
        if (sum[SW]) begin
          m = {sum[SW:2], sum[1] | sum[0]};
          e = e + 13'd1;
        end else begin
          lz = 13'd56;
          for (int i = 0; i < SW; i++) if (sum[i]) lz = 13'(SW - 1 - i);
          sh = (lz < e) ? lz : (e - 13'd1);
          m = sum[SW-1:0] << sh;
          e = e - sh;
        end
        tiny = !m[SW-1];
        inexact = |m[2:0];
        inc = m[2] & (m[1] | m[0] | m[3]);
        rm = {1'b0, m[SW-1:3]} + {{(MW+1){1'b0}}, inc};
        if (rm[MW+1]) begin
          rm = rm >> 1;
          e = e + 13'd1;
        end
        if (e >= 13'(XMAX)) begin
          res = {sl, XMAX, {MW{1'b0}}};
          ovf = 1'b1;
          prec = 1'b1;
        end else begin
          res = {sl, rm[MW] ? e[XW-1:0] : {XW{1'b0}}, rm[MW-1:0]};
          prec = inexact;
          unf = tiny & inexact;
        end
      end
    end
    return {prec, unf, ovf, den, inv, res};
  endfunction

  logic [VW-1:0] lane_res;
  logic [4:0]    lane_flg [LANES];
  logic          wide;
  logic [4:0]    flg_lo, flg_hi;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign {lane_flg[k], lane_res[k*FW +: FW]} = lane_op(op_a[k*FW +: FW], op_b[k*FW +: FW], (k % 2) == 0);
  end

  always_comb begin
    flg_lo = '0;
    flg_hi = '0;
    for (int k = 0; k < LANES; k++) begin
      if (k < LANES / 2) flg_lo = flg_lo | lane_flg[k];
      else               flg_hi = flg_hi | lane_flg[k];
    end
  end

  assign wide = mode[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      flags     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result[HALF-1:0]  <= lane_res[HALF-1:0];
        result[VW-1:HALF] <= wide ? lane_res[VW-1:HALF] :
                             (mode[0] ? '0 : old_dst[VW-1:HALF]);
        flags <= flg_lo | (wide ? flg_hi : 5'b0);
      end
    end
  end
endmodule

module fp64_altsub_unit_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [1:0]   mode,
  input logic [255:0] old_dst,
  input logic         out_valid,
  input logic [255:0] result,
  input logic [4:0]   flags
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R12
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R12
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(result) && $stable(flags)); // R12
  AST_LEGACY_UPPER: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && mode == 2'd0) |=> result[255:128] == $past(old_dst[255:128])); // R3
  AST_NARROW_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && mode == 2'd1) |=> result[255:128] == '0); // R4
  AST_NAN_INVALID: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && result[63:0] == 64'hFFF8000000000000) |-> flags[0]); // R7
  AST_OVERFLOW_INEXACT: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && flags[2]) |-> flags[4]); // R9
  AST_UNDERFLOW_INEXACT: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && flags[3]) |-> flags[4]); // R11
endmodule

bind fp64_altsub_unit fp64_altsub_unit_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .old_dst(old_dst),
  .out_valid(out_valid), .result(result), .flags(flags)
);

// File: tb/fp64_altsub_unit_test.sv
module fp64_altsub_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [255:0] op_a = '0, op_b = '0, old_dst = '0;
  logic out_valid;
  logic [255:0] result;
  logic [4:0] flags;
  int total = 0, bad = 0;
  bit done = 1'b0;

  fp64_altsub_unit uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .op_a(op_a), .op_b(op_b), .old_dst(old_dst), .out_valid(out_valid),
    .result(result), .flags(flags));

  always #2 clk = ~clk;

  logic [63:0] vals [16] = '{
    64'h0000000000000000, 64'h8000000000000000, 64'h3FF0000000000000, 64'hBFF0000000000000,
    64'h3FF8000000000000, 64'h3FF0000000000001, 64'h3CA0000000000000, 64'h0000000000000001,
    64'h800FFFFFFFFFFFFF, 64'h0010000000000000, 64'h7FEFFFFFFFFFFFFF, 64'hFFEFFFFFFFFFFFFF,
    64'h7FF0000000000000, 64'hFFF0000000000000, 64'h7FF8000000000000, 64'h7FF0000000000001};

  function automatic logic [68:0] ref_op(input logic [63:0] a, input logic [63:0] b, input logic sub);
    logic an, bn, ai, bi, sa, sb, den, inv, ovf, unf, prec;
    real x, y, s, bb, err;
    logic [63:0] r;
    sa = a[63]; sb = b[63] ^ sub;
    an = (a[62:52] == 11'h7FF) && (a[51:0] != 0);
    bn = (b[62:52] == 11'h7FF) && (b[51:0] != 0);
    ai = (a[62:52] == 11'h7FF) && (a[51:0] == 0);
    bi = (b[62:52] == 11'h7FF) && (b[51:0] == 0);
    den = ((a[62:52] == 0) && (a[51:0] != 0)) || ((b[62:52] == 0) && (b[51:0] != 0));
    inv = 0; ovf = 0; unf = 0; prec = 0;
    if (an || bn || (ai && bi && sa != sb)) begin
      r = 64'hFFF8000000000000; inv = 1;
    end else begin
      x = $bitstoreal(a);
      y = $bitstoreal(b);
      if (sub) y = -y;
      s = x + y;
      r = $realtobits(s);
      if (!ai && !bi && r[62:52] == 11'h7FF) begin
        ovf = 1; prec = 1;
      end else if (!ai && !bi) begin
        bb = s - x;
        err = (x - (s - bb)) + (y - bb);
        prec = (err != 0.0);
        unf = prec && (r[62:52] == 0);
      end
    end
    return {prec, unf, ovf, den, inv, r};
  endfunction

  task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] m, input logic [255:0] a, input logic [255:0] b,
                     input logic [255:0] od);
    logic [255:0] er;
    logic [4:0] ef;
    logic [68:0] q;
    er = '0; ef = '0;
    for (int k = 0; k < 4; k++) begin
      q = ref_op(a[k*64 +: 64], b[k*64 +: 64], (k % 2) == 0);
      if (k < 2 || m[1]) begin
        er[k*64 +: 64] = q[63:0];
        ef = ef | q[68:64];
      end else if (m == 2'd0) begin
        er[k*64 +: 64] = od[k*64 +: 64];
      end
    end
    @(negedge clk);
    mode = m; op_a = a; op_b = b; old_dst = od; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R12 out_valid", {255'b0, out_valid}, 256'd1);
    check("R1 lane0 sub", {192'b0, result[63:0]}, {192'b0, er[63:0]});
    check("R2 lane1 add", {192'b0, result[127:64]}, {192'b0, er[127:64]});
    if (m == 2'd0) check("R3 upper kept", {128'b0, result[255:128]}, {128'b0, er[255:128]});
    else if (m == 2'd1) check("R4 upper zero", {128'b0, result[255:128]}, 256'b0);
    else begin
      check("R1 R5 lane2 sub", {192'b0, result[191:128]}, {192'b0, er[191:128]});
      check("R2 R5 lane3 add", {192'b0, result[255:192]}, {192'b0, er[255:192]});
    end
    check("R12 flags", {251'b0, flags}, {251'b0, ef});
  endtask

  task automatic direct(input string tag, input logic [1:0] m, input logic [63:0] a,
                        input logic [63:0] b, input logic [63:0] r0, input logic [4:0] f);
    @(negedge clk);
    mode = m; op_a = {4{a}}; op_b = {4{b}}; old_dst = '0; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " result"}, {192'b0, result[63:0]}, {192'b0, r0});
    check({tag, " flags"}, {251'b0, flags}, {251'b0, f});
  endtask

  function automatic logic [63:0] rnd_fp();
    logic [63:0] v;
    v = {$urandom, $urandom};
    v[62:52] = 11'(1023 - 60 + ($urandom % 120));
    if (($urandom % 8) == 0) v[62:52] = 11'd0;
    return v;
  endfunction

  initial begin
    #400000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R12 reset valid", {255'b0, out_valid}, 256'b0);
    check("R12 reset result", result, 256'b0);
    check("R12 reset flags", {251'b0, flags}, 256'b0);
    rst_n = 1'b1;
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        run(2'd2, {4{vals[i]}}, {4{vals[j]}}, '0);
    for (int n = 0; n < 400; n++)
      run(2'(n % 4), {rnd_fp(), rnd_fp(), rnd_fp(), rnd_fp()},
          {rnd_fp(), rnd_fp(), rnd_fp(), rnd_fp()}, {$urandom, $urandom, $urandom, $urandom,
           $urandom, $urandom, $urandom, $urandom});
    direct("R6 tie to even down", 2'd2, 64'h3FF0000000000000, 64'hBCA0000000000000, 64'h3FF0000000000000, 5'b10000);
    direct("R6 tie to even up", 2'd2, 64'h3FF0000000000001, 64'hBCA0000000000000, 64'h3FF0000000000002, 5'b10000);
    direct("R7 snan", 2'd1, 64'h7FF0000000000001, 64'h3FF0000000000000, 64'hFFF8000000000000, 5'b00001);
    direct("R7 inf minus inf", 2'd1, 64'h7FF0000000000000, 64'h7FF0000000000000, 64'hFFF8000000000000, 5'b00001);
    direct("R8 x minus x", 2'd1, 64'hBFF8000000000000, 64'hBFF8000000000000, 64'h0000000000000000, 5'b00000);
    direct("R8 neg zero", 2'd1, 64'h8000000000000000, 64'h0000000000000000, 64'h8000000000000000, 5'b00000);
    direct("R9 overflow", 2'd1, 64'hFFEFFFFFFFFFFFFF, 64'h7FEFFFFFFFFFFFFF, 64'hFFF0000000000000, 5'b10100);
    direct("R10 denormal", 2'd1, 64'h0000000000000003, 64'h0000000000000001, 64'h0000000000000002, 5'b00010);
    direct("R11 inexact", 2'd1, 64'h3FF0000000000000, 64'h3C30000000000000, 64'h3FF0000000000000, 5'b10000);
    @(negedge clk);
    mode = 2'd1; op_a = {64'h7FEFFFFFFFFFFFFF, 64'h7FEFFFFFFFFFFFFF, 64'h3FF0000000000000, 64'h3FF0000000000000};
    op_b = {64'h7FEFFFFFFFFFFFFF, 64'hFFEFFFFFFFFFFFFF, 64'h3FF0000000000000, 64'h3FF0000000000000};
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R4 upper lane flags ignored", {251'b0, flags}, 256'b0);
    @(negedge clk);
    check("R12 valid drops", {255'b0, out_valid}, 256'b0);
    check("R12 result held", {192'b0, result[127:0]}, {128'b0, 64'h4000000000000000, 64'h0000000000000000});
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule